// File: doc/BRIEF.md
# Word-to-Byte Stream Serializer with Tail Suppression

This block turns a stream of 36-bit buffer words into a stream of 8-bit bytes for a network interface. Each word carries four data bytes in its upper 32 bits. The bytes leave in order, starting with the most significant byte. On ordinary words the low four bits carry no meaning. On the word flagged as the last one of a buffer, those four bits form a suppress mask. A byte whose mask bit is set is dropped from the stream, and no filler byte takes its place.

Both sides use valid/ready handshakes. An input word is taken in a cycle where `in_valid` and `in_ready` are both high. The output presents one byte at a time. The byte and `out_valid` hold steady until `out_ready` accepts them. `in_ready` stays low while any kept byte of the current word is still waiting. A downstream stall therefore holds back the input side and loses nothing. If a last word has every byte suppressed, it is absorbed in its accept cycle and sends nothing.

Top module: `wbs_serializer`

## Requirements
- R1: After reset is released, `out_valid` is 0 and `in_ready` is 1.
- R2: The data bytes of a word are sent in this order: `in_word[35:28]` first, then `[27:20]`, then `[19:12]`, then `[11:4]`. The first byte appears on `out_byte` in the cycle after the word is accepted.
- R3: When `in_last` is 0, all four bytes are sent, whatever the value of `in_word[3:0]`.
- R4: When `in_last` is 1, bit 3 of the word suppresses the first byte, bit 2 the second, bit 1 the third and bit 0 the fourth. A suppressed byte is skipped, and the next kept byte follows at once.
- R5: A last word with `in_word[3:0]` = 4'b0111 sends only its first byte.
- R6: A last word with `in_word[3:0]` = 4'b1111 sends no byte. `in_ready` is 1 again in the cycle after it is accepted.
- R7: `in_ready` is 0 from the cycle after an accept that keeps at least one byte. It returns to 1 in the cycle after the last kept byte has been handshaken. `in_ready` and `out_valid` are never both 1.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_byte` does not change in the next cycle.
- R9: A word offered with `in_valid` while `in_ready` is 0 has no effect. The current word's bytes are not altered, and the offered word is taken only once `in_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_word | input | 36 | Four data bytes in [35:4], suppress mask in [3:0] |
| in_valid | input | 1 | Input word is valid |
| in_last | input | 1 | Input word is the last word of its buffer |
| in_ready | output | 1 | Serializer can accept a word |
| out_byte | output | 8 | Current output byte |
| out_valid | output | 1 | `out_byte` is valid |
| out_ready | input | 1 | Downstream accepts `out_byte` |

## Verification
The bench offers words with random suppress nibbles, both on last words and on ordinary words. A design that reads the mask on every word would lose bytes of ordinary words. A reversed mask mapping would drop the wrong end of a word, and the case of nibble 0111 exposes it directly. Last words with every byte suppressed are sent back to back. A design that wastes a cycle or emits a stray byte on them is caught by the per-cycle comparison of `in_ready` and `out_valid`. Random stalls and words held on `in_valid` during busy periods go after designs that advance or reload the byte under back-pressure.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  // Default geometry: four byte lanes of eight bits plus one mask bit per lane.
  localparam int unsigned LANES_DEF  = 4;
  localparam int unsigned LANE_W_DEF = 8;
endpackage

// File: rtl/wbs_unpack.sv
// Splits an input word into byte lanes (lane 0 sent first) and per-lane
// suppress bits (mask bit LANES-1 belongs to lane 0).
module wbs_unpack #(
  parameter int unsigned LANES  = wbs_pkg::LANES_DEF,
  parameter int unsigned LANE_W = wbs_pkg::LANE_W_DEF,
  localparam int unsigned WORD_W = LANES * (LANE_W + 1)
) (
  input  logic [WORD_W-1:0]             word,
  output logic [LANES-1:0][LANE_W-1:0]  lanes,
  output logic [LANES-1:0]              sup
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = word[WORD_W-1-g*LANE_W -: LANE_W];
    assign sup[g]   = word[LANES-1-g];
  end
endmodule

// File: rtl/wbs_keep.sv
// Decides which lanes are transmitted: the mask only counts on last words.
module wbs_keep #(
  parameter int unsigned LANES = wbs_pkg::LANES_DEF
) (
  input  logic             last,
  input  logic [LANES-1:0] sup,
  output logic [LANES-1:0] keep
);
  always_comb begin
    if (last) keep = ~sup;
    else      keep = '1;
  end
endmodule

// File: rtl/wbs_pick.sv
// Finds the lowest-numbered pending lane (the next byte to send).
module wbs_pick #(
  parameter int unsigned LANES = wbs_pkg::LANES_DEF,
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES-1:0] pend,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
  end
  assign any = |pend;
endmodule

// File: rtl/wbs_serializer.sv
// Word-to-byte serializer with tail-byte suppression on the last word.
module wbs_serializer #(
  parameter int unsigned LANES  = wbs_pkg::LANES_DEF,
  parameter int unsigned LANE_W = wbs_pkg::LANE_W_DEF,
  localparam int unsigned WORD_W = LANES * (LANE_W + 1),
  localparam int unsigned IDX_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic [LANE_W-1:0] out_byte,
  output logic              out_valid,
  input  logic              out_ready
);
  logic [LANES-1:0][LANE_W-1:0] lanes_in;
  logic [LANES-1:0]             sup_in;
  logic [LANES-1:0]             keep_in;

  logic [LANES-1:0][LANE_W-1:0] lanes_q;
  logic [LANES-1:0]             pend_q;
  logic                         any_pend;
  logic [IDX_W-1:0]             cur_idx;
  logic                         take_word;
  logic                         send_byte;

  wbs_unpack #(.LANES(LANES), .LANE_W(LANE_W)) i_unpack (
    .word  (in_word),
    .lanes (lanes_in),
    .sup   (sup_in)
  );

  wbs_keep #(.LANES(LANES)) i_keep (
    .last (in_last),
    .sup  (sup_in),
    .keep (keep_in)
  );

  wbs_pick #(.LANES(LANES)) i_pick (
    .pend (pend_q),
    .any  (any_pend),
    .idx  (cur_idx)
  );

  assign in_ready  = !any_pend;
  assign take_word = in_valid && in_ready;
  assign out_valid = any_pend;
  assign out_byte  = lanes_q[cur_idx];
  assign send_byte = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      lanes_q <= '0;
    end else if (take_word) begin
      pend_q  <= keep_in;
      lanes_q <= lanes_in;
    end else if (send_byte) begin
      pend_q[cur_idx] <= 1'b0;
    end
  end
endmodule

// File: rtl/wbs_serializer_chk.sv
// Property checker, attached to every wbs_serializer instance.
module wbs_serializer_chk #(
  parameter int unsigned LANES  = wbs_pkg::LANES_DEF,
  parameter int unsigned LANE_W = wbs_pkg::LANE_W_DEF,
  localparam int unsigned WORD_W = LANES * (LANE_W + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] in_word,
  input logic              in_valid,
  input logic              in_last,
  input logic              in_ready,
  input logic [LANE_W-1:0] out_byte,
  input logic              out_valid,
  input logic              out_ready
);
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (in_ready && !out_valid)); // R1

  AST_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_last) |=>
      (out_valid && out_byte == $past(in_word[WORD_W-1 -: LANE_W]))); // R2

  AST_FULL_WORD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_last) |=> !in_ready); // R3

  AST_ALL_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last && (&in_word[LANES-1:0])) |=>
      (in_ready && !out_valid)); // R6

  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R7

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte))); // R8

  AST_BUSY_IGNORES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !out_ready) |=> $stable(out_byte)); // R9
endmodule

bind wbs_serializer wbs_serializer_chk #(.LANES(LANES), .LANE_W(LANE_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_word   (in_word),
  .in_valid  (in_valid),
  .in_last   (in_last),
  .in_ready  (in_ready),
  .out_byte  (out_byte),
  .out_valid (out_valid),
  .out_ready (out_ready)
);

// File: tb/test_wbs_serializer.sv
`timescale 1ns/1ps
module test_wbs_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [35:0] in_word = '0;
  logic        in_valid = 1'b0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic [7:0]  out_byte;
  logic        out_valid;
  logic        out_ready = 1'b1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R2";
  bit stall_mode = 1'b0;
  bit took = 1'b0;
  byte unsigned pend[$];

  always #5 clk = ~clk;

  wbs_serializer i_wbs_serializer (
    .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
    .in_last(in_last), .in_ready(in_ready), .out_byte(out_byte),
    .out_valid(out_valid), .out_ready(out_ready)
  );

  // Behavioural reference: a queue of bytes still owed for the current word.
  always @(posedge clk) begin
    took = 1'b0;
    if (!rst_n) begin
      pend.delete();
    end else if (pend.size() > 0) begin
      if (out_ready) void'(pend.pop_front());
    end else if (in_valid) begin
      took = 1'b1;
      for (int b = 0; b < 4; b++) begin
        if (!(in_last && in_word[3-b])) pend.push_back(in_word[35-8*b -: 8]);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Per-cycle comparison away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      check("R7", in_ready, pend.size() == 0, {cur_req, " in_ready"});
      check(cur_req, out_valid, pend.size() > 0, "out_valid");
      if (pend.size() > 0) check(cur_req, out_byte, pend[0], "out_byte");
    end
    if (stall_mode) out_ready = ($urandom % 3) == 0;
    else            out_ready = 1'b1;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send_word(input logic [35:0] w, input logic l);
    @(negedge clk);
    in_word = w; in_last = l; in_valid = 1'b1;
    forever begin
      @(posedge clk); #1;
      if (took) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    while (pend.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {out_valid, in_ready}, 2'b01, "reset state");

    cur_req = "R2"; send_word(36'h123456789, 1'b0); drain();
    cur_req = "R3"; send_word(36'hA1B2C3D4F, 1'b0); drain();
    cur_req = "R4"; send_word(36'h11223344A, 1'b1); drain();
    cur_req = "R4"; send_word(36'h556677885, 1'b1); drain();
    cur_req = "R5"; send_word(36'hDEADBEEF7, 1'b1); drain();
    cur_req = "R6";
    send_word(36'hCAFEF00DF, 1'b1);
    send_word(36'h99887766F, 1'b1);
    @(negedge clk);
    check("R6", {out_valid, in_ready}, 2'b01, "idle after full suppression");
    cur_req = "R9";
    send_word(36'h0F1E2D3C0, 1'b0);
    send_word(36'h4B5A69781, 1'b1);
    drain();
    cur_req = "R8";
    stall_mode = 1'b1;
    for (int n = 0; n < 300; n++) begin
      send_word({$urandom, 4'($urandom)}, 1'($urandom));
    end
    drain();
    stall_mode = 1'b0;
    @(negedge clk);
    drain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule